// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the transaction engine of an SMBus host controller. Software-visible registers outside the block hold a protocol code, an address byte (target address in the upper seven bits, direction in bit 0), a command byte, two data bytes and a block buffer. A one-cycle start pulse hands these operands to the engine. The engine then steps through an ordered series of byte-level bus events: start in either direction, send a byte, receive a byte, NACK and stop. It emits one event per clock cycle on a simple event port that a bit-level bus driver or a behavioural target model consumes.

The target answers in the same cycle. On a start event it drives an acknowledge, and on a receive event it drives the received byte. The engine writes read results into the data result registers and the block result buffer. At the end of the sequence it raises a done flag or an error flag, and that flag holds until the next start. A missing acknowledge on a start aborts the transfer with a stop. A code that selects no protocol is refused at once and produces no bus events.

Top module: `smbus_host_seq`

## Requirements
- R1: Protocol codes 0 (quick), 1 (send/receive byte), 2 (byte data), 3 (word) and 5 (block) are accepted. A start with code 4, 6 or 7 produces no bus event and sets err_o in the cycle after the start pulse.
- R2: Every event carries addr_rw_i[7:1] on ev_addr_o. Bit 0 of the address byte selects read (1) or write (0). Event codes on ev_kind_o are: 0 start-send, 1 start-receive, 2 send byte, 3 receive byte, 4 NACK, 5 stop.
- R3: A quick command is a single start in the requested direction, followed in the next cycle by a stop, with no data bytes.
- R4: A send-byte transfer is start-send, then send of the command byte, then stop. A receive-byte transfer is start-receive, then one receive into data0_o, then NACK, then stop. A NACK is always followed by a stop.
- R5: A byte-data write sends the command byte and then data0. A byte-data read sends the command byte, issues a repeated start-receive, receives one byte into data0_o, NACKs and stops.
- R6: Words travel low byte first. A write sends data0 and then data1. A read puts the first received byte in data0_o and the second in data1_o.
- R7: A block write sends the command byte, then the count min(data0_i, 32), then that many bytes taken from blk_wr_i (byte i at bits 8i+7:8i), then a stop.
- R8: A block read sends the command byte and a repeated start, then receives the count byte. A count above 32 is treated as 0. That many further bytes go into blk_rd_o byte 0 upward, then NACK and stop follow, and data0_o holds the clamped count.
- R9: If the target does not acknowledge a start event, the next event is a stop and the transfer ends with err_o=1 and done_o=0.
- R10: After reset all outputs are 0. busy_o is high from the cycle after an accepted start until the stop event has been issued. A successful sequence ends with done_o=1 and err_o=0, and done_o and err_o are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transaction start pulse, honoured when idle |
| proto_i | input | 3 | Protocol code |
| addr_rw_i | input | 8 | Target address [7:1], read flag [0] |
| cmd_i | input | 8 | Command byte (also the byte for send-byte) |
| data0_i | input | 8 | Write data 0 / block write count |
| data1_i | input | 8 | Write data 1 (word high byte) |
| blk_wr_i | input | 256 | Block write buffer, byte i at [8i+7:8i] |
| tgt_ack_i | input | 1 | Target acknowledge, sampled on start events |
| rx_byte_i | input | 8 | Byte from target, sampled on receive events |
| ev_valid_o | output | 1 | A bus event is presented this cycle |
| ev_kind_o | output | 3 | Event code |
| ev_addr_o | output | 7 | Target address of the event |
| ev_byte_o | output | 8 | Byte of a send event |
| data0_o | output | 8 | Read result low byte / block read count |
| data1_o | output | 8 | Read result high byte |
| blk_rd_o | output | 256 | Block read buffer, byte i at [8i+7:8i] |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last transfer completed |
| err_o | output | 1 | Last transfer refused or aborted |

## Verification
The assertions assume that start_i is a one-cycle pulse and is only given while the engine is idle. They also assume that blk_wr_i holds steady for the whole of a block write, because the engine reads the buffer during the transfer rather than copying it. The bench raises start_i for exactly one cycle, waits for busy_o to drop before the next start, and changes the operands only between transfers. The target model acknowledges only its own address and derives each received byte from its position in the transfer. This lets the bench check data placement and count clamping across every protocol code, both directions, block counts 0 to 40 and targets that do not answer.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

  localparam logic [2:0] P_QUICK = 3'd0;
  localparam logic [2:0] P_BYTE  = 3'd1;
  localparam logic [2:0] P_BDATA = 3'd2;
  localparam logic [2:0] P_WORD  = 3'd3;
  localparam logic [2:0] P_BLOCK = 3'd5;

  typedef enum logic [2:0] {
    EV_START_TX = 3'd0,
    EV_START_RX = 3'd1,
    EV_SEND     = 3'd2,
    EV_RECV     = 3'd3,
    EV_NACK     = 3'd4,
    EV_STOP     = 3'd5
  } ev_kind_e;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == P_QUICK) || (p == P_BYTE) || (p == P_BDATA) ||
           (p == P_WORD) || (p == P_BLOCK);
  endfunction

  // Outgoing block length: saturate at the buffer size.
  function automatic logic [7:0] wr_count(input logic [7:0] d, input logic [7:0] mx);
    return (d > mx) ? mx : d;
  endfunction

  // Incoming block length: an oversize count means an empty block.
  function automatic logic [7:0] rd_count(input logic [7:0] d, input logic [7:0] mx);
    return (d > mx) ? 8'd0 : d;
  endfunction

endpackage

// File: rtl/smbus_seq_ctrl.sv
module smbus_seq_ctrl
  import smbus_seq_pkg::*;
#(
  parameter int BLK_MAX = 32,
  parameter int IDXW    = $clog2(BLK_MAX),
  parameter int CW      = $clog2(BLK_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      proto,
  input  logic [7:0]      addr_rw,
  input  logic [7:0]      cmd,
  input  logic [7:0]      d0,
  input  logic [7:0]      d1,
  input  logic            tgt_ack,
  input  logic [7:0]      rx_byte,
  input  logic [7:0]      blk_byte,
  output logic [IDXW-1:0] blk_idx,
  output logic            ev_valid,
  output logic [2:0]      ev_kind,
  output logic [6:0]      ev_addr,
  output logic [7:0]      ev_byte,
  output logic            cap_d0,
  output logic            cap_d1,
  output logic            cap_cnt,
  output logic            cap_blk,
  output logic [7:0]      cnt_val,
  output logic            busy,
  output logic            done,
  output logic            err
);

  typedef enum logic [3:0] {
    S_IDLE, S_STW, S_CMD, S_TX0, S_TX1, S_TXC, S_TXB,
    S_STR, S_RX0, S_RX1, S_RXC, S_RXB, S_NACK, S_STOP
  } st_e;

  localparam logic [7:0] MAX8 = 8'(BLK_MAX);

  st_e             st, nx;
  logic [2:0]      proto_q;
  logic            rd_q, fail_q, done_q, err_q;
  logic [6:0]      addr_q;
  logic [7:0]      cmd_q, d0_q, d1_q;
  logic [CW-1:0]   cnt_q;
  logic [IDXW-1:0] idx_q;

  // Named internal events
  wire idle       = (st == S_IDLE);
  wire start_ok   = start && idle && proto_ok(proto);
  wire start_bad  = start && idle && !proto_ok(proto);
  wire at_start   = (st == S_STW) || (st == S_STR);
  wire no_ack     = at_start && !tgt_ack;
  wire blk_last   = (CW'(idx_q) + CW'(1)) == cnt_q;
  wire [7:0] wr_n = wr_count(d0_q, MAX8);
  wire [7:0] rd_n = rd_count(rx_byte, MAX8);

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE: if (start_ok)
                nx = ((proto == P_QUICK && addr_rw[0]) ||
                      (proto == P_BYTE && addr_rw[0])) ? S_STR : S_STW;
      S_STW:  nx = (!tgt_ack || proto_q == P_QUICK) ? S_STOP : S_CMD;
      S_CMD:  if (proto_q == P_BYTE)       nx = S_STOP;
              else if (rd_q)               nx = S_STR;
              else if (proto_q == P_BLOCK) nx = S_TXC;
              else                         nx = S_TX0;
      S_TX0:  nx = (proto_q == P_WORD) ? S_TX1 : S_STOP;
      S_TX1:  nx = S_STOP;
      S_TXC:  nx = (wr_n == 8'd0) ? S_STOP : S_TXB;
      S_TXB:  nx = blk_last ? S_STOP : S_TXB;
      S_STR:  if (!tgt_ack || proto_q == P_QUICK) nx = S_STOP;
              else if (proto_q == P_BLOCK)        nx = S_RXC;
              else                                nx = S_RX0;
      S_RX0:  nx = (proto_q == P_WORD) ? S_RX1 : S_NACK;
      S_RX1:  nx = S_NACK;
      S_RXC:  nx = (rd_n == 8'd0) ? S_NACK : S_RXB;
      S_RXB:  nx = blk_last ? S_NACK : S_RXB;
      S_NACK: nx = S_STOP;
      S_STOP: nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; proto_q <= '0; rd_q <= 1'b0; addr_q <= '0;
      cmd_q <= '0; d0_q <= '0; d1_q <= '0; cnt_q <= '0; idx_q <= '0;
      fail_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st <= nx;
      if (start && idle) begin
        done_q <= 1'b0;
        err_q  <= start_bad;
      end
      if (start_ok) begin
        proto_q <= proto; rd_q <= addr_rw[0]; addr_q <= addr_rw[7:1];
        cmd_q <= cmd; d0_q <= d0; d1_q <= d1; fail_q <= 1'b0;
      end
      if (no_ack) fail_q <= 1'b1;
      if (st == S_TXC) begin cnt_q <= CW'(wr_n); idx_q <= '0; end
      if (st == S_RXC) begin cnt_q <= CW'(rd_n); idx_q <= '0; end
      if ((st == S_TXB || st == S_RXB) && !blk_last) idx_q <= idx_q + IDXW'(1);
      if (st == S_STOP) begin
        done_q <= !fail_q;
        err_q  <= fail_q;
      end
    end
  end

  always_comb begin
    ev_byte = 8'd0;
    unique case (st)
      S_CMD:   ev_byte = cmd_q;
      S_TX0:   ev_byte = d0_q;
      S_TX1:   ev_byte = d1_q;
      S_TXC:   ev_byte = wr_n;
      S_TXB:   ev_byte = blk_byte;
      default: ev_byte = 8'd0;
    endcase
  end

  always_comb begin
    unique case (st)
      S_STW:                        ev_kind = EV_START_TX;
      S_STR:                        ev_kind = EV_START_RX;
      S_CMD, S_TX0, S_TX1, S_TXC, S_TXB: ev_kind = EV_SEND;
      S_RX0, S_RX1, S_RXC, S_RXB:   ev_kind = EV_RECV;
      S_NACK:                       ev_kind = EV_NACK;
      S_STOP:                       ev_kind = EV_STOP;
      default:                      ev_kind = EV_START_TX;
    endcase
  end

  assign ev_valid = !idle;
  assign ev_addr  = addr_q;
  assign blk_idx  = idx_q;
  assign cap_d0   = (st == S_RX0);
  assign cap_d1   = (st == S_RX1);
  assign cap_cnt  = (st == S_RXC);
  assign cap_blk  = (st == S_RXB);
  assign cnt_val  = rd_n;
  assign busy     = !idle;
  assign done     = done_q;
  assign err      = err_q;

  // R1: refused code raises err and stays off the bus
  a_r1_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> err && !ev_valid);

  // R9: unanswered start is closed with a stop
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    no_ack |=> ev_valid && ev_kind == EV_STOP);

  // R3: answered quick start goes straight to stop
  a_r3_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (at_start && tgt_ack && proto_q == P_QUICK) |=> ev_kind == EV_STOP);

  // R4: NACK is always followed by stop
  a_r4_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_kind == EV_NACK) |=> ev_valid && ev_kind == EV_STOP);

  // R5: repeated start of a command read comes right after the command byte
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STR && proto_q != P_QUICK && proto_q != P_BYTE) |-> $past(st) == S_CMD);

  // R7: block data index stays inside the clamped count
  a_r7_blk_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TXB || st == S_RXB) |-> (CW'(idx_q) < cnt_q && cnt_q <= CW'(BLK_MAX)));

  // R10: completion flags are exclusive
  a_r10_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

endmodule

// File: rtl/smbus_seq_rdcap.sv
module smbus_seq_rdcap #(
  parameter int BLK_MAX = 32,
  parameter int IDXW    = $clog2(BLK_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_d0,
  input  logic               cap_d1,
  input  logic               cap_cnt,
  input  logic               cap_blk,
  input  logic [7:0]         rx_byte,
  input  logic [7:0]         cnt_val,
  input  logic [IDXW-1:0]    blk_idx,
  output logic [7:0]         data0,
  output logic [7:0]         data1,
  output logic [BLK_MAX*8-1:0] blk
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data0 <= '0;
      data1 <= '0;
    end else begin
      if (cap_d0)       data0 <= rx_byte;
      else if (cap_cnt) data0 <= cnt_val;
      if (cap_d1)       data1 <= rx_byte;
    end
  end

  for (genvar g = 0; g < BLK_MAX; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   blk[g*8 +: 8] <= '0;
      else if (cap_blk && blk_idx == IDXW'(g))      blk[g*8 +: 8] <= rx_byte;
    end
  end

  // R6: high byte of a word is only taken right after the low byte
  a_r6_lo_first: assert property (@(posedge clk) disable iff (!rst_n)
    cap_d1 |-> $past(cap_d0));

  // R8: block bytes are only captured after the count byte or another block byte
  a_r8_cnt_first: assert property (@(posedge clk) disable iff (!rst_n)
    cap_blk |-> ($past(cap_cnt) || $past(cap_blk)));

endmodule

// File: rtl/smbus_host_seq.sv
module smbus_host_seq #(
  parameter int BLK_MAX = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [2:0]           proto_i,
  input  logic [7:0]           addr_rw_i,
  input  logic [7:0]           cmd_i,
  input  logic [7:0]           data0_i,
  input  logic [7:0]           data1_i,
  input  logic [BLK_MAX*8-1:0] blk_wr_i,
  input  logic                 tgt_ack_i,
  input  logic [7:0]           rx_byte_i,
  output logic                 ev_valid_o,
  output logic [2:0]           ev_kind_o,
  output logic [6:0]           ev_addr_o,
  output logic [7:0]           ev_byte_o,
  output logic [7:0]           data0_o,
  output logic [7:0]           data1_o,
  output logic [BLK_MAX*8-1:0] blk_rd_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);

  localparam int IDXW = $clog2(BLK_MAX);
  localparam int CW   = $clog2(BLK_MAX + 1);

  logic [IDXW-1:0] blk_idx;
  logic [7:0]      blk_byte, cnt_val;
  logic            cap_d0, cap_d1, cap_cnt, cap_blk;

  assign blk_byte = blk_wr_i[blk_idx*8 +: 8];

  smbus_seq_ctrl #(.BLK_MAX(BLK_MAX), .IDXW(IDXW), .CW(CW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .proto(proto_i),
    .addr_rw(addr_rw_i), .cmd(cmd_i), .d0(data0_i), .d1(data1_i),
    .tgt_ack(tgt_ack_i), .rx_byte(rx_byte_i), .blk_byte(blk_byte),
    .blk_idx(blk_idx), .ev_valid(ev_valid_o), .ev_kind(ev_kind_o),
    .ev_addr(ev_addr_o), .ev_byte(ev_byte_o), .cap_d0(cap_d0),
    .cap_d1(cap_d1), .cap_cnt(cap_cnt), .cap_blk(cap_blk),
    .cnt_val(cnt_val), .busy(busy_o), .done(done_o), .err(err_o)
  );

  smbus_seq_rdcap #(.BLK_MAX(BLK_MAX), .IDXW(IDXW)) i_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_d0(cap_d0), .cap_d1(cap_d1),
    .cap_cnt(cap_cnt), .cap_blk(cap_blk), .rx_byte(rx_byte_i),
    .cnt_val(cnt_val), .blk_idx(blk_idx), .data0(data0_o),
    .data1(data1_o), .blk(blk_rd_o)
  );

endmodule

// File: tb/test_smbus_host_seq.sv
module test_smbus_host_seq;

  localparam int PERIOD = 10;
  localparam int BM     = 32;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [2:0] proto_i = '0;
  logic [7:0] addr_rw_i = '0, cmd_i = '0, data0_i = '0, data1_i = '0;
  logic [BM*8-1:0] blk_wr_i;
  logic tgt_ack_i;
  logic [7:0] rx_byte_i, first_rx = '0;
  logic ev_valid_o, busy_o, done_o, err_o;
  logic [2:0] ev_kind_o;
  logic [6:0] ev_addr_o;
  logic [7:0] ev_byte_o, data0_o, data1_o;
  logic [BM*8-1:0] blk_rd_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  smbus_host_seq #(.BLK_MAX(BM)) i_smbus_host_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .proto_i(proto_i),
    .addr_rw_i(addr_rw_i), .cmd_i(cmd_i), .data0_i(data0_i), .data1_i(data1_i),
    .blk_wr_i(blk_wr_i), .tgt_ack_i(tgt_ack_i), .rx_byte_i(rx_byte_i),
    .ev_valid_o(ev_valid_o), .ev_kind_o(ev_kind_o), .ev_addr_o(ev_addr_o),
    .ev_byte_o(ev_byte_o), .data0_o(data0_o), .data1_o(data1_o),
    .blk_rd_o(blk_rd_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [7:0] pat(input int k);
    return 8'((8'hC3 ^ (k * 29)) & 8'hFF);
  endfunction

  // Target model: answers its own address, bytes indexed by receive position.
  int rx_idx = 0;
  assign tgt_ack_i = ev_valid_o && (ev_addr_o == TGT);
  assign rx_byte_i = (rx_idx == 0) ? first_rx : pat(rx_idx);
  always @(posedge clk)
    if (start_i) rx_idx <= 0;
    else if (ev_valid_o && ev_kind_o == 3'd3) rx_idx <= rx_idx + 1;

  // Event log, sampled away from the active edge
  int n_log = 0;
  logic [2:0] log_kind [64];
  logic [7:0] log_byte [64];
  logic [6:0] log_addr [64];
  always @(negedge clk) begin
    if (start_i) n_log = 0;
    else if (ev_valid_o && n_log < 64) begin
      log_kind[n_log] = ev_kind_o;
      log_byte[n_log] = ev_byte_o;
      log_addr[n_log] = ev_addr_o;
      n_log++;
    end
  end

  int n_exp;
  logic [2:0] exp_kind [64];
  logic [7:0] exp_byte [64];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input int b);
    exp_kind[n_exp] = 3'(k);
    exp_byte[n_exp] = 8'(b);
    n_exp++;
  endtask

  task automatic run(input int p, input int rd, input logic [6:0] a7,
                     input int c, input int d0, input int d1, input int fr);
    bit valid, ack;
    int n;
    string tag;
    valid = (p == 0 || p == 1 || p == 2 || p == 3 || p == 5);
    ack = (a7 == TGT);
    if (!valid) tag = "R1";
    else if (!ack) tag = "R9";
    else if (p == 0) tag = "R3";
    else if (p == 1) tag = "R4";
    else if (p == 2) tag = "R5";
    else if (p == 3) tag = "R6";
    else tag = rd ? "R8" : "R7";

    @(posedge clk); #1;
    proto_i = 3'(p); addr_rw_i = {a7, 1'(rd)}; cmd_i = 8'(c);
    data0_i = 8'(d0); data1_i = 8'(d1); first_rx = 8'(fr); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (!busy_o) break;
    end

    // Expected event sequence from the requirements
    n_exp = 0;
    if (valid) begin
      if ((p == 0 || p == 1) && rd == 1) push(1, 0); else push(0, 0);
      if (!ack) push(5, 0);
      else if (p == 0) push(5, 0);
      else if (p == 1 && rd == 0) begin push(2, c); push(5, 0); end
      else if (p == 1) begin push(3, 0); push(4, 0); push(5, 0); end
      else if (rd == 0) begin
        push(2, c);
        if (p == 2) push(2, d0);
        if (p == 3) begin push(2, d0); push(2, d1); end
        if (p == 5) begin
          n = (d0 > BM) ? BM : d0;
          push(2, n);
          for (int i = 0; i < n; i++) push(2, 8'h30 + i);
        end
        push(5, 0);
      end else begin
        push(2, c); push(1, 0); push(3, 0);
        if (p == 3) push(3, 0);
        if (p == 5) begin
          n = (fr > BM) ? 0 : fr;
          for (int i = 0; i < n; i++) push(3, 0);
        end
        push(4, 0); push(5, 0);
      end
    end

    check(n_log == n_exp, {tag, " event count"}, n_log, n_exp);
    for (int i = 0; i < n_exp && i < n_log; i++) begin
      check(log_kind[i] == exp_kind[i], {tag, " event kind"}, log_kind[i], exp_kind[i]);
      if (exp_kind[i] == 3'd2)
        check(log_byte[i] == exp_byte[i], {tag, " sent byte"}, log_byte[i], exp_byte[i]);
      check(log_addr[i] == a7, "R2 event address", log_addr[i], a7);
    end
    check(err_o == !(valid && ack), "R10 err flag", err_o, !(valid && ack));
    check(done_o == (valid && ack), "R10 done flag", done_o, valid && ack);

    if (valid && ack && rd == 1) begin
      if (p == 1 || p == 2 || p == 3)
        check(data0_o == 8'(fr), {tag, " data0 result"}, data0_o, fr);
      if (p == 3)
        check(data1_o == pat(1), "R6 data1 high byte", data1_o, pat(1));
      if (p == 5) begin
        n = (fr > BM) ? 0 : fr;
        check(data0_o == 8'(n), "R8 block count", data0_o, n);
        for (int i = 0; i < n; i++)
          check(blk_rd_o[i*8 +: 8] == pat(i + 1), "R8 block byte",
                blk_rd_o[i*8 +: 8], pat(i + 1));
      end
    end
  endtask

  initial begin
    for (int i = 0; i < BM; i++) blk_wr_i[i*8 +: 8] = 8'(8'h30 + i);
    repeat (3) @(posedge clk);
    #1;
    check(!ev_valid_o && !busy_o && !done_o && !err_o, "R10 reset flags",
          {ev_valid_o, busy_o, done_o, err_o}, 0);
    check(data0_o == 0 && data1_o == 0 && blk_rd_o == '0, "R10 reset data",
          data0_o, 0);
    rst_n = 1'b1;

    // Every protocol code, both directions
    for (int p = 0; p < 8; p++)
      for (int rd = 0; rd < 2; rd++) begin
        run(p, rd, TGT, 8'h11 + p, 8'h5A, 8'hA5, 8'h3C + p);
        run(p, rd, TGT, 8'hE0 + p, 8'h07, 8'hFE, 8'h01);
      end

    // Block count sweep across the clamp in both directions
    for (int n = 0; n <= 40; n++) begin
      run(5, 0, TGT, 8'h40, n, 0, 0);
      run(5, 1, TGT, 8'h41, 0, 0, n);
    end
    run(5, 1, TGT, 8'h42, 0, 0, 255);
    run(5, 0, TGT, 8'h43, 255, 0, 0);

    // Unanswered target on every valid code
    for (int p = 0; p < 6; p++)
      for (int rd = 0; rd < 2; rd++)
        run(p, rd, 7'h23, 8'h99, 8'h12, 8'h34, 8'h56);

    // Word with distinct halves
    run(3, 1, TGT, 8'h77, 0, 0, 8'hB4);
    run(3, 0, TGT, 8'h78, 8'h01, 8'h80, 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule